// File: doc/BRIEF.md
# SDRAM Power-Up Mode-Set Sequencer

This block drives the command and address pins of one SDRAM rank from power-up to the point where the memory is ready for normal traffic. After reset is released it first waits for a programmable power-on interval. This wait can be skipped when reset is known to have been held long enough. It then issues one all-bank precharge, eight auto-refresh commands and one mode-register write. Between these commands it inserts idle (NOP) cycles whose counts come from two 2-bit configuration fields. After one further idle cycle it raises a done flag. A memory controller hands the pins to its normal scheduler once that flag is high.

The mode-register value selects burst length 1, CAS latency 2 or 3, and a write-burst choice: burst writes, or single writes with burst reads. The value is placed on the address pins shifted by the data bus width. A 16-bit bus shifts it left by one and a 32-bit bus by two.

The controller is a single state machine with eight states:
- `ST_PWRON`: power-on wait, clock enable low.
- `ST_PRECHARGE`: the precharge command.
- `ST_GAP_RP`: idle after the precharge.
- `ST_REFRESH`: one refresh command.
- `ST_GAP_RC`: idle after a refresh.
- `ST_MODE_SET`: the mode write.
- `ST_GAP_MRS`: one idle cycle after the mode write.
- `ST_DONE`: terminal state.

Its transitions are:
- `ST_PWRON` to `ST_PRECHARGE` when the wait counter matches or the bypass is set.
- `ST_PRECHARGE` to `ST_GAP_RP` always.
- `ST_GAP_RP` to `ST_REFRESH` when the gap counter matches.
- `ST_REFRESH` to `ST_GAP_RC` always.
- `ST_GAP_RC` to `ST_REFRESH` on a gap match while fewer than eight refreshes have been issued.
- `ST_GAP_RC` to `ST_MODE_SET` on a gap match after the eighth refresh.
- `ST_MODE_SET` to `ST_GAP_MRS` always.
- `ST_GAP_MRS` to `ST_DONE` always.
- `ST_DONE` stays in `ST_DONE` until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and during the power-on wait, the outputs are CKE=0, CS#=1, RAS#=1, CAS#=1, WE#=1, the address is 0 and done is 0.
- R2: With the bypass input low and wait field P, the power-on wait lasts P+1 cycles after reset release. With the bypass input high it lasts exactly 1 cycle.
- R3: Exactly one precharge-all follows the wait. Its encoding is CKE=1, CS#=0, RAS#=0, CAS#=1, WE#=0, with only address bit 10 set.
- R4: After the precharge, precharge-gap field value N produces N+1 NOP cycles. A NOP is CKE=1, CS#=0, RAS#=1, CAS#=1, WE#=1 with address 0.
- R5: Exactly eight refresh commands are issued. Each is encoded CKE=1, CS#=0, RAS#=0, CAS#=0, WE#=1 with address 0.
- R6: Refresh-gap field value N produces N+1 NOP cycles after each refresh, including the eighth, before the next command.
- R7: One mode write follows, encoded CKE=1, CS#=0, RAS#=0, CAS#=0, WE#=0. Its address is the mode value shifted left by 1 (`cfg_bus32`=0) or 2 (`cfg_bus32`=1). The mode value is 0x20 for `cfg_cas3`=0 or 0x30 for `cfg_cas3`=1, plus 0x200 when `cfg_single_write`=1.
- R8: Exactly one NOP follows the mode write. Done rises in the next cycle and then stays high, with NOP on the pins, until reset.
- R9: Done is 0 in every cycle before the one described in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts the sequence |
| cfg_pwron_cycles | input | PWRON_W | Power-on wait field P (P+1 cycles) |
| cfg_skip_wait | input | 1 | 1 = skip the power-on wait |
| cfg_rp_gap | input | GAP_W | Idle field after the precharge (N+1 cycles) |
| cfg_rc_gap | input | GAP_W | Idle field after each refresh (N+1 cycles) |
| cfg_cas3 | input | 1 | 0 = CAS latency 2, 1 = CAS latency 3 |
| cfg_single_write | input | 1 | 1 = burst read with single write |
| cfg_bus32 | input | 1 | 0 = 16-bit data bus, 1 = 32-bit data bus |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
The bench targets several corner cases, each tied to a specific wrong behaviour:
- Gap fields at 0 and at 3. A design that used N instead of N+1 idle cycles would emit a command one cycle early.
- The ninth and missing refresh cases. An off-by-one refresh counter would send the mode write one refresh too early or too late.
- All four combinations of latency and bus width, and both write modes. A wrong shift or a wrong write-burst bit would put a bad value on the address pins during the mode write.
- Power-on wait field 0 and bypass. A wait that did not count P+1 cycles, or ignored the bypass, would shift the whole command stream.
- Done timing. A done that rose on the mode-write cycle would hand the pins to the scheduler without the required idle cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_PWRON,
        ST_PRECHARGE,
        ST_GAP_RP,
        ST_REFRESH,
        ST_GAP_RC,
        ST_MODE_SET,
        ST_GAP_MRS,
        ST_DONE
    } init_state_t;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PALL,
        CMD_REF,
        CMD_MRS
    } sd_cmd_t;

    // Address bit that selects all banks on a precharge
    localparam int unsigned PALL_BIT  = 10;
    // Mode word layout
    localparam int unsigned MODE_W    = 10;
    localparam int unsigned CL_LSB    = 4;
    localparam int unsigned WBURST_BIT = 9;

endpackage

// File: rtl/init_cycle_counter.sv
module init_cycle_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/init_mode_word.sv
module init_mode_word
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              cas3,
    input  logic              single_write,
    input  logic              bus32,
    output logic [ADDR_W-1:0] mode_addr
);

    logic [MODE_W-1:0] mode_val;
    logic [ADDR_W-1:0] mode_ext;

    always_comb begin
        mode_val                       = '0;
        mode_val[CL_LSB +: 3]          = {1'b0, 1'b1, cas3};  // 2 or 3
        mode_val[WBURST_BIT]           = single_write;
        mode_ext                       = ADDR_W'(mode_val);
    end

    // Placement on the address pins follows the data bus width
    always_comb begin
        if (bus32) begin
            mode_addr = mode_ext << 2;
        end else begin
            mode_addr = mode_ext << 1;
        end
    end

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  sd_cmd_t           cmd,
    input  logic [ADDR_W-1:0] mode_addr,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;

    always_comb begin
        cke   = 1'b1;
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        unique case (cmd)
            CMD_DESEL: begin
                cke  = 1'b0;
                cs_n = 1'b1;
            end
            CMD_NOP: begin
            end
            CMD_PALL: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                addr  = PALL_ADDR;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = mode_addr;
            end
            default: begin
                cke  = 1'b0;
                cs_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned PWRON_W   = 16,
    parameter int unsigned GAP_W     = 2,
    parameter int unsigned REF_COUNT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PWRON_W-1:0] cfg_pwron_cycles,
    input  logic               cfg_skip_wait,
    input  logic [GAP_W-1:0]   cfg_rp_gap,
    input  logic [GAP_W-1:0]   cfg_rc_gap,
    input  logic               cfg_cas3,
    input  logic               cfg_single_write,
    input  logic               cfg_bus32,
    output logic               sd_cke,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [ADDR_W-1:0]  sd_addr,
    output logic               init_done
);

    localparam int unsigned REF_W = $clog2(REF_COUNT + 1);

    init_state_t state, state_nx;
    sd_cmd_t     cmd;

    logic [PWRON_W-1:0] pw_cnt;
    logic [GAP_W-1:0]   gap_cnt;
    logic [REF_W-1:0]   ref_cnt;
    logic [GAP_W-1:0]   gap_limit;
    logic               pw_hit, gap_hit, ref_all, in_gap;
    logic [ADDR_W-1:0]  mode_addr;

    assign pw_hit    = (pw_cnt == cfg_pwron_cycles);
    assign in_gap    = (state == ST_GAP_RP) || (state == ST_GAP_RC);
    assign gap_limit = (state == ST_GAP_RP) ? cfg_rp_gap : cfg_rc_gap;
    assign gap_hit   = (gap_cnt == gap_limit);
    assign ref_all   = (ref_cnt == REF_W'(REF_COUNT));

    init_cycle_counter #(.W(PWRON_W)) u_pw_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (1'b0),
        .inc  ((state == ST_PWRON) && !pw_hit),
        .cnt  (pw_cnt)
    );

    init_cycle_counter #(.W(GAP_W)) u_gap_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!in_gap),
        .inc  (in_gap),
        .cnt  (gap_cnt)
    );

    init_cycle_counter #(.W(REF_W)) u_ref_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (1'b0),
        .inc  (state == ST_REFRESH),
        .cnt  (ref_cnt)
    );

    init_mode_word #(.ADDR_W(ADDR_W)) u_mode (
        .cas3        (cfg_cas3),
        .single_write(cfg_single_write),
        .bus32       (cfg_bus32),
        .mode_addr   (mode_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PWRON;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRON:     if (cfg_skip_wait || pw_hit) state_nx = ST_PRECHARGE;
            ST_PRECHARGE: state_nx = ST_GAP_RP;
            ST_GAP_RP:    if (gap_hit) state_nx = ST_REFRESH;
            ST_REFRESH:   state_nx = ST_GAP_RC;
            ST_GAP_RC:    if (gap_hit) state_nx = ref_all ? ST_MODE_SET : ST_REFRESH;
            ST_MODE_SET:  state_nx = ST_GAP_MRS;
            ST_GAP_MRS:   state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_DONE;
            default:      state_nx = ST_PWRON;
        endcase
    end

    // Outputs
    always_comb begin
        cmd       = CMD_NOP;
        init_done = 1'b0;
        unique case (state)
            ST_PWRON:     cmd = CMD_DESEL;
            ST_PRECHARGE: cmd = CMD_PALL;
            ST_GAP_RP:    cmd = CMD_NOP;
            ST_REFRESH:   cmd = CMD_REF;
            ST_GAP_RC:    cmd = CMD_NOP;
            ST_MODE_SET:  cmd = CMD_MRS;
            ST_GAP_MRS:   cmd = CMD_NOP;
            ST_DONE: begin
                cmd       = CMD_NOP;
                init_done = 1'b1;
            end
            default:      cmd = CMD_DESEL;
        endcase
    end

    init_cmd_drive #(.ADDR_W(ADDR_W)) u_drive (
        .cmd      (cmd),
        .mode_addr(mode_addr),
        .cke      (sd_cke),
        .cs_n     (sd_cs_n),
        .ras_n    (sd_ras_n),
        .cas_n    (sd_cas_n),
        .we_n     (sd_we_n),
        .addr     (sd_addr)
    );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);

    logic is_nop, is_pall, is_ref, is_mrs;
    assign is_nop  = sd_cke && !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign is_pall = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
    assign is_ref  = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
    assign is_mrs  = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;

    // R1: clock enable low always means deselected
    a_r1_desel_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> sd_cs_n);

    // R1: once clock enable rises it stays up until reset
    a_r1_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);

    // R3: precharge-all carries only the all-bank address bit
    a_r3_pall_addr: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> (sd_addr == (ADDR_W'(1) << 10)) && sd_cke);

    // R5: refresh issued with clock enable high
    a_r5_ref_cke: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> sd_cke && !init_done);

    // R8: mode write followed by one idle cycle without done
    a_r8_mrs_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> is_nop && !init_done);

    // R8: done is sticky and only NOPs are driven after it
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r8_done_nop: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .init_done(init_done)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

    localparam int ADDR_W  = 13;
    localparam int PWRON_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [PWRON_W-1:0] cfg_pwron_cycles = '0;
    logic               cfg_skip_wait = 1'b0;
    logic [1:0]         cfg_rp_gap = '0;
    logic [1:0]         cfg_rc_gap = '0;
    logic               cfg_cas3 = 1'b0;
    logic               cfg_single_write = 1'b0;
    logic               cfg_bus32 = 1'b0;
    logic               sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [ADDR_W-1:0]  sd_addr;

    always #2 clk = ~clk;  // 250 MHz

    sdram_init_seq u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_pwron_cycles(cfg_pwron_cycles),
        .cfg_skip_wait   (cfg_skip_wait),
        .cfg_rp_gap      (cfg_rp_gap),
        .cfg_rc_gap      (cfg_rc_gap),
        .cfg_cas3        (cfg_cas3),
        .cfg_single_write(cfg_single_write),
        .cfg_bus32       (cfg_bus32),
        .sd_cke          (sd_cke),
        .sd_cs_n         (sd_cs_n),
        .sd_ras_n        (sd_ras_n),
        .sd_cas_n        (sd_cas_n),
        .sd_we_n         (sd_we_n),
        .sd_addr         (sd_addr),
        .init_done       (init_done)
    );

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    logic [ADDR_W+5:0] exp_q[$];
    string             tag_q[$];

    function automatic logic [ADDR_W+5:0] mk(input logic d, input logic ke, input logic cs,
                                            input logic ra, input logic ca, input logic we,
                                            input logic [ADDR_W-1:0] a);
        return {d, ke, cs, ra, ca, we, a};
    endfunction

    function automatic logic [ADDR_W+5:0] act_vec();
        return {init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr};
    endfunction

    task automatic push(input logic [ADDR_W+5:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Monitor: compare each cycle's outputs against the scoreboard
    always @(negedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            logic [ADDR_W+5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (act_vec() !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, act_vec(), e);
            end
        end
    end

    task automatic run_case(input int p, input bit skip, input int rp, input int rc,
                            input bit cas3, input bit sw, input bit b32);
        logic [ADDR_W-1:0] maddr;
        int waitc;
        cfg_pwron_cycles = PWRON_W'(p);
        cfg_skip_wait    = skip;
        cfg_rp_gap       = 2'(rp);
        cfg_rc_gap       = 2'(rc);
        cfg_cas3         = cas3;
        cfg_single_write = sw;
        cfg_bus32        = b32;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (act_vec() !== mk(0, 0, 1, 1, 1, 1, '0)) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=%h", act_vec(), mk(0, 0, 1, 1, 1, 1, '0));
        end
        // Build the expected command stream (R2..R9)
        maddr = ADDR_W'((sw ? 32'h200 : 32'h0) + (cas3 ? 32'h30 : 32'h20)) << (b32 ? 2 : 1);
        waitc = skip ? 1 : p + 1;
        for (int i = 0; i < waitc; i++) push(mk(0, 0, 1, 1, 1, 1, '0), "R1/R2 power-on wait");
        push(mk(0, 1, 0, 0, 1, 0, ADDR_W'(1) << 10), "R3/R9 precharge-all");
        for (int i = 0; i <= rp; i++) push(mk(0, 1, 0, 1, 1, 1, '0), "R4/R9 precharge gap");
        for (int r = 0; r < 8; r++) begin
            push(mk(0, 1, 0, 0, 0, 1, '0), "R5/R9 refresh");
            for (int i = 0; i <= rc; i++) push(mk(0, 1, 0, 1, 1, 1, '0), "R6/R9 refresh gap");
        end
        push(mk(0, 1, 0, 0, 0, 0, maddr), "R7/R9 mode write");
        push(mk(0, 1, 0, 1, 1, 1, '0), "R8 idle after mode write");
        for (int i = 0; i < 4; i++) push(mk(1, 1, 0, 1, 1, 1, '0), "R8 done held");
        @(posedge clk);
        #1 rst_n = 1'b1;
        mon_en = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        @(posedge clk);
        mon_en = 1'b0;
    endtask

    initial begin
        run_case(0, 1, 0, 0, 0, 0, 0);  // 0x040
        run_case(5, 0, 3, 2, 1, 1, 1);  // 0x8C0
        run_case(0, 0, 1, 3, 1, 1, 0);  // 0x460
        run_case(2, 0, 2, 1, 0, 0, 1);  // 0x080
        run_case(9, 1, 3, 3, 0, 1, 0);  // 0x440, bypass overrides long wait
        run_case(1, 0, 0, 1, 1, 0, 1);  // 0x0C0
        run_case(3, 0, 1, 0, 0, 1, 1);  // 0x880
        run_case(0, 0, 0, 0, 1, 0, 0);  // 0x060
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule